// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of a raster LCD panel in the pixel clock domain. One 32-bit configuration word sets the line length and the three blanking intervals. The block then counts pixel clocks through four phases in a fixed order: active pixels, front porch, a sync or line-clock pulse, and back porch. It drives a data-enable strobe, the sync/line-clock output, a one-cycle end-of-line strobe and the current pixel column.

The line length is given in groups of 16 pixels with a minus-one code. Each of the three blanking fields is also minus-one coded. A word written through the synchronous write port is held in a staging register and moves into the working copy only when a line wraps, so the line in progress keeps its timing. Two inputs choose how the pulse is shown on the sync output. In active-panel mode it is a horizontal sync whose polarity can be selected. In passive-panel mode it is a line clock that is always active high.

Top module: `lcd_hline_timer`

## Requirements
- R1: The data-enable output is high for 16 × (N + 1) consecutive clocks per line, where N is the 6-bit code in bits 7:2 of the configuration word (16 to 1024 pixels).
- R2: After the last active pixel, the front porch lasts F + 1 clocks, where F is bits 23:16. During the front porch data-enable is low and the pulse is inactive.
- R3: The sync/line-clock pulse lasts W + 1 clocks, where W is bits 15:8.
- R4: The back porch lasts B + 1 clocks, where B is bits 31:24. The end-of-line output is high for exactly one clock, on the last back-porch clock.
- R5: Each line runs active, front porch, pulse, back porch, and the next clock is the first active pixel of the next line. The line period is the sum of the four phase lengths.
- R6: The configuration read port returns the last written word with bits 1:0 forced to zero. Those two bits have no effect on timing.
- R7: A word written during a line does not change that line. It takes effect from the first active pixel of the following line.
- R8: In active-panel mode (passive = 0), the sync output is high during the pulse and low otherwise when polarity = 0. It is inverted when polarity = 1.
- R9: In passive-panel mode (passive = 1), the sync output is a line clock. It is high during the pulse and low otherwise, whatever the polarity input.
- R10: The column output counts 0, 1, … up to the active count − 1 while data-enable is high, and reads 0 while data-enable is low.
- R11: While reset is high, data-enable, sync, end-of-line, column and read-back are all zero. The clock after reset is released shows column 0 of a line with 16 active pixels and one clock each of front porch, pulse and back porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word, bits 1:0 read as zero |
| panel_passive | input | 1 | 1 = passive panel (line clock), 0 = active panel (sync) |
| sync_invert | input | 1 | Inverts the sync output in active-panel mode |
| de | output | 1 | Data enable, high on active pixels |
| hsync | output | 1 | Horizontal sync or line clock |
| eol | output | 1 | One-cycle strobe on the last back-porch clock |
| col | output | 10 | Pixel column during the active region |

## Verification
The reset configuration checks the shortest line, 16 pixels with single-clock porches and pulse. An all-ones word checks the 1024-pixel, 256-clock extremes, and a mid-range word with its reserved bits set shows that the low bits are dropped. Random words, mode settings and polarity settings then vary every field independently. Because the four phase lengths come from different fields, a swapped or mis-decoded field shows up as a wrong length in one particular phase. Every configuration change is made right after an end-of-line strobe, and the line that follows is measured against the old word. This separates deferred loading from immediate loading.

// File: rtl/lcd_hline_pkg.sv
package lcd_hline_pkg;
  localparam int WORD_W    = 32;
  localparam int RSV_W     = 2;
  localparam int PPL_W     = 6;
  localparam int GRAN_LOG2 = 4;
  localparam int FLD_W     = 8;
  localparam int COL_W     = PPL_W + GRAN_LOG2;
  localparam int CNT_W     = (COL_W > FLD_W) ? COL_W : FLD_W;
  localparam int PULSE_LSB = 8;
  localparam int FRONT_LSB = 16;
  localparam int BACK_LSB  = 24;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_FRONT  = 2'd1,
    PH_PULSE  = 2'd2,
    PH_BACK   = 2'd3
  } hphase_e;

  typedef struct packed {
    logic [FLD_W-1:0] back;
    logic [FLD_W-1:0] front;
    logic [FLD_W-1:0] pulse;
    logic [PPL_W-1:0] groups;
  } hcfg_t;

  function automatic hcfg_t decode_word(input logic [WORD_W-1:0] w);
    hcfg_t c;
    c.groups = w[RSV_W +: PPL_W];
    c.pulse  = w[PULSE_LSB +: FLD_W];
    c.front  = w[FRONT_LSB +: FLD_W];
    c.back   = w[BACK_LSB +: FLD_W];
    return c;
  endfunction
endpackage

// File: rtl/lcd_hcfg_regs.sv
module lcd_hcfg_regs
  import lcd_hline_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              line_wrap,
  output logic [WORD_W-1:0] rdata,
  output hcfg_t             work_cfg
);
  logic [WORD_W-1:0] stage_q;
  wire unused_rsv = &{1'b0, wdata[RSV_W-1:0]};

  // staging word, reserved bits never stored
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (we) begin
      stage_q <= {wdata[WORD_W-1:RSV_W], {RSV_W{1'b0}}};
    end
  end

  // working copy moves only when a line wraps
  always_ff @(posedge clk) begin
    if (rst) begin
      work_cfg <= '0;
    end else if (line_wrap) begin
      work_cfg <= decode_word(stage_q);
    end
  end

  assign rdata = stage_q;
endmodule

// File: rtl/lcd_hphase_seq.sv
module lcd_hphase_seq
  import lcd_hline_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  hcfg_t            cfg,
  output hphase_e          phase,
  output logic [CNT_W-1:0] cnt,
  output logic             line_last
);
  logic [CNT_W-1:0] limit;
  logic             at_limit;
  hphase_e          phase_nx;

  always_comb begin
    limit = '0;
    unique case (phase)
      PH_ACTIVE: limit[COL_W-1:0] = {cfg.groups, {GRAN_LOG2{1'b1}}};
      PH_FRONT:  limit[FLD_W-1:0] = cfg.front;
      PH_PULSE:  limit[FLD_W-1:0] = cfg.pulse;
      default:   limit[FLD_W-1:0] = cfg.back;
    endcase
  end

  assign at_limit  = (cnt == limit);
  assign line_last = at_limit && (phase == PH_BACK);

  always_comb begin
    unique case (phase)
      PH_ACTIVE: phase_nx = PH_FRONT;
      PH_FRONT:  phase_nx = PH_PULSE;
      PH_PULSE:  phase_nx = PH_BACK;
      default:   phase_nx = PH_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ACTIVE;
      cnt   <= '0;
    end else if (at_limit) begin
      phase <= phase_nx;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_hout_stage.sv
module lcd_hout_stage
  import lcd_hline_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  hphase_e          phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             line_last,
  input  logic             passive,
  input  logic             invert,
  output logic             de,
  output logic             hsync,
  output logic             eol,
  output logic [COL_W-1:0] col
);
  logic in_active;
  logic in_pulse;
  logic sync_nx;

  assign in_active = (phase == PH_ACTIVE);
  assign in_pulse  = (phase == PH_PULSE);
  // line clock ignores the polarity select
  assign sync_nx   = passive ? in_pulse : (in_pulse ^ invert);

  generate
    if (CNT_W > COL_W) begin : g_wide
      wire unused_hi = &{1'b0, cnt[CNT_W-1:COL_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      de    <= 1'b0;
      hsync <= 1'b0;
      eol   <= 1'b0;
      col   <= '0;
    end else begin
      de    <= in_active;
      hsync <= sync_nx;
      eol   <= line_last;
      col   <= in_active ? cnt[COL_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/lcd_hline_timer.sv
module lcd_hline_timer
  import lcd_hline_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              panel_passive,
  input  logic              sync_invert,
  output logic              de,
  output logic              hsync,
  output logic              eol,
  output logic [COL_W-1:0]  col
);
  hcfg_t            work_cfg;
  hphase_e          phase;
  logic [CNT_W-1:0] cnt;
  logic             line_last;

  lcd_hcfg_regs regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .line_wrap(line_last), .rdata(cfg_rdata), .work_cfg(work_cfg)
  );

  lcd_hphase_seq seq_i (
    .clk(clk), .rst(rst), .cfg(work_cfg),
    .phase(phase), .cnt(cnt), .line_last(line_last)
  );

  lcd_hout_stage out_i (
    .clk(clk), .rst(rst), .phase(phase), .cnt(cnt), .line_last(line_last),
    .passive(panel_passive), .invert(sync_invert),
    .de(de), .hsync(hsync), .eol(eol), .col(col)
  );
endmodule

// File: rtl/lcd_hline_timer_chk.sv
module lcd_hline_timer_chk
  import lcd_hline_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              panel_passive,
  input logic              sync_invert,
  input logic              de,
  input logic              hsync,
  input logic              eol,
  input logic [COL_W-1:0]  col
);
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!de && !eol && !hsync && col == '0 && cfg_rdata == '0));

  p_eol_single_r4: assert property (@(posedge clk) disable iff (rst)
    eol |=> !eol);

  p_eol_blank_r5: assert property (@(posedge clk) disable iff (rst)
    eol |-> !de);

  p_next_line_r5: assert property (@(posedge clk) disable iff (rst)
    eol |=> de);

  p_rdback_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == {$past(cfg_wdata[WORD_W-1:RSV_W]), {RSV_W{1'b0}}});

  p_col_step_r10: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de) && !$past(rst)) |-> col == $past(col) + 1'b1);

  p_col_first_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> col == '0);

  p_col_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !de |-> col == '0);

  p_sync_level_r8: assert property (@(posedge clk) disable iff (rst)
    (de && !$past(rst) && !$past(panel_passive)) |-> hsync == $past(sync_invert));

  p_lineclk_low_r9: assert property (@(posedge clk) disable iff (rst)
    (de && !$past(rst) && $past(panel_passive)) |-> !hsync);
endmodule

bind lcd_hline_timer lcd_hline_timer_chk chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .panel_passive(panel_passive),
  .sync_invert(sync_invert), .de(de), .hsync(hsync), .eol(eol), .col(col)
);

// File: tb/lcd_hline_timer_tb.sv
module lcd_hline_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        panel_passive = 1'b0;
  logic        sync_invert = 1'b0;
  logic        de, hsync, eol;
  logic [9:0]  col;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_flag = 0;

  int m_a, m_f, m_s, m_b;
  bit m_order, m_col, m_idle, m_eol;

  always #10 clk = ~clk;

  lcd_hline_timer dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .panel_passive(panel_passive),
    .sync_invert(sync_invert), .de(de), .hsync(hsync), .eol(eol), .col(col)
  );

  function automatic int exp_act(logic [31:0] w);   return 16 * (int'(w[7:2]) + 1); endfunction
  function automatic int exp_front(logic [31:0] w); return int'(w[23:16]) + 1; endfunction
  function automatic int exp_pulse(logic [31:0] w); return int'(w[15:8]) + 1; endfunction
  function automatic int exp_back(logic [31:0] w);  return int'(w[31:24]) + 1; endfunction
  function automatic logic idle_level();
    return panel_passive ? 1'b0 : sync_invert;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done_flag) begin
      chk(1'b0, "watchdog", "run did not finish", cycles, 0);
      report();
    end
  end

  task automatic wait_eol();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!eol && n < 5000);
  endtask

  // classifies each clock of one line, stops at the end-of-line strobe
  task automatic measure();
    int n = 0;
    bit fin = 0;
    m_a = 0; m_f = 0; m_s = 0; m_b = 0;
    m_order = 1; m_col = 1; m_idle = 1; m_eol = 1;
    while (!fin && n < 5000) begin
      @(negedge clk);
      n++;
      if (n == 1) cfg_we = 1'b0;
      if (de) begin
        if (col != 10'(m_a)) m_col = 0;
        if (hsync != idle_level()) m_idle = 0;
        if (m_f + m_s + m_b != 0) m_order = 0;
        m_a++;
      end else begin
        if (col != 10'd0) m_col = 0;
        if (hsync != idle_level()) begin
          if (m_b != 0 || m_a == 0) m_order = 0;
          m_s++;
        end else if (m_s == 0) begin
          if (m_a == 0) m_order = 0;
          m_f++;
        end else begin
          m_b++;
        end
      end
      if (eol) begin
        fin = 1;
        if (de || hsync != idle_level()) m_eol = 0;
      end
    end
  endtask

  task automatic check_line(input logic [31:0] w, input string tag);
    chk(m_a == exp_act(w),   "R1", {tag, " active count"}, m_a, exp_act(w));
    chk(m_f == exp_front(w), "R2", {tag, " front porch"},  m_f, exp_front(w));
    chk(m_s == exp_pulse(w), "R3", {tag, " pulse width"},  m_s, exp_pulse(w));
    chk(m_b == exp_back(w) && m_eol, "R4", {tag, " back porch / eol"}, m_b, exp_back(w));
    chk(m_order && (m_a + m_f + m_s + m_b ==
        exp_act(w) + exp_front(w) + exp_pulse(w) + exp_back(w)),
        "R5", {tag, " order and period"}, m_a + m_f + m_s + m_b,
        exp_act(w) + exp_front(w) + exp_pulse(w) + exp_back(w));
    chk(m_col, "R10", {tag, " column sequence"}, int'(m_col), 1);
    chk(m_idle, panel_passive ? "R9" : "R8", {tag, " idle sync level"},
        int'(m_idle), 1);
  endtask

  // new word written just after a line wraps: that line must keep the old word
  task automatic apply(input logic [31:0] w_old, input logic [31:0] w_new,
                       input string tag);
    wait_eol();
    cfg_wdata = w_new;
    cfg_we    = 1'b1;
    measure();
    check_line(w_old, {tag, " R7 line after write keeps old word"});
    chk(cfg_rdata == {w_new[31:2], 2'b00}, "R6", {tag, " readback"},
        int'(cfg_rdata), int'({w_new[31:2], 2'b00}));
    measure();
    check_line(w_new, {tag, " new word"});
  endtask

  initial begin
    logic [31:0] cur;
    void'($urandom(32'd5179));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!de && !hsync && !eol && col == 0 && cfg_rdata == 0, "R11",
        "outputs during reset", int'({de, hsync, eol}), 0);
    rst = 1'b0;
    measure();
    check_line(32'h0, "R11 first line after reset");
    cur = 32'h0;

    apply(cur, 32'h0302_0417, "mid word with reserved bits set"); cur = 32'h0302_0414;
    apply(cur, 32'hFFFF_FFFF, "all ones");                        cur = 32'hFFFF_FFFC;
    apply(cur, 32'h0000_0002, "minimum");                         cur = 32'h0;

    // R8 inverted sync in active mode
    wait_eol();
    sync_invert = 1'b1;
    apply(cur, 32'h0501_0A08, "R8 inverted"); cur = 32'h0501_0A08;

    // R9 passive mode ignores the polarity select
    wait_eol();
    panel_passive = 1'b1;
    apply(cur, 32'h0204_0306, "R9 passive"); cur = 32'h0204_0304;

    for (int i = 0; i < 12; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[7:2] = w[7:2] & 6'h1F;
      wait_eol();
      panel_passive = 1'($urandom);
      sync_invert   = 1'($urandom);
      apply(cur, w, "random");
      cur = {w[31:2], 2'b00};
    end

    done_flag = 1;
    report();
  end
endmodule